// File: doc/BRIEF.md
# Single-cycle RISC subset processor

This block is a 32-bit processor core that retires one instruction per clock cycle. In each cycle it fetches a word from its own instruction memory at the program counter and decodes it. It reads two source registers, runs the ALU and, where the instruction calls for it, reads or writes a separate data memory. The result is written to the register file and the next program counter is loaded on the rising edge that closes the cycle. The supported instructions are word load and store, the five register-to-register operations add, subtract, and, or and set-on-less-than, branch-if-equal, and an unconditional jump.

The control decoder turns the opcode and function fields into a small struct of strobes for the datapath. The datapath holds the program counter, the register file, the sign extender, the ALU, a dedicated branch-target adder and both memory arrays. Both memories are plain arrays inside the datapath, and an enclosing environment loads them by hierarchical reference before reset is released. For observation, the core drives its current PC and instruction word, its register write-back bus and its data-memory write bus as outputs.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset holds the PC at 0 and keeps the write-back and store strobes low. The first cycle after release executes the word at address 0.
- R2: Any instruction that is neither a branch nor a jump loads PC+4 into the PC at the closing edge, so exactly one instruction completes per cycle and the PC stays word aligned.
- R3: When opcode bits [31:26] are 000000, the word is a register operation with source fields [25:21] and [20:16] and destination field [15:11]. Function bits [5:0] of 100000, 100010, 100100 and 100101 select add, subtract (first source minus second), bitwise and, and bitwise or. The result appears on the write-back bus in the same cycle and can be read by the next instruction.
- R4: Function code 101010 writes 1 when the first source is less than the second as signed 32-bit numbers, and 0 otherwise.
- R5: Register 0 always reads as zero. A write that targets it has no effect.
- R6: Opcode 100011 (load) reads the data word at the first source plus the sign-extended 16-bit field [15:0] and writes it to the register named by field [20:16].
- R7: Opcode 101011 (store) writes the register named by [20:16] to the address formed as in R6 at the closing edge. The store strobe is high only for this opcode, and a store writes no register.
- R8: Opcode 000100 (branch) compares the two source registers. When they are equal, the next PC is PC+4 plus the sign-extended field [15:0] shifted left by 2; otherwise it is PC+4. A branch writes neither a register nor memory.
- R9: Opcode 000010 (jump) loads the PC with bits [31:28] of PC+4, followed by field [25:0], followed by two zero bits.
- R10: The write-back strobe is high exactly for register operations and loads, and the write-back address is [15:11] for register operations and [20:16] for loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc | output | 32 | Address of the instruction executing this cycle |
| instr | output | 32 | Instruction word executing this cycle |
| wbEn | output | 1 | Register write-back strobe for this cycle |
| wbAddr | output | 5 | Destination register of the write-back |
| wbData | output | 32 | Value being written back |
| memWe | output | 1 | Data-memory store strobe for this cycle |
| memAddr | output | 32 | Byte address computed by the ALU (load/store address) |
| memWdata | output | 32 | Data presented for a store |

## Verification
Every output of an instruction is combinational within that instruction's cycle, and the PC and register or memory updates land on the rising edge that ends it. The bench therefore compares the write-back and store buses at the falling edge of the cycle in which the instruction executes. It checks the PC produced by that instruction one sample later. A reference interpreter in the bench steps once per sample. The bench also sweeps every pairing of six register values, including the signed extremes and equal operands, through all five register operations. Loads are compared against values stored earlier in the program, which exposes any store at the wrong address.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {CLS_ADD, CLS_SUB, CLS_FUNC} alu_class_e;

  typedef struct packed {
    logic    regWrite;
    logic    regDstRd;
    logic    aluSrcImm;
    logic    memToReg;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    jump;
    alu_op_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int REG_COUNT = 32,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         wrEn,
  input  logic [$clog2(REG_COUNT)-1:0] wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [$clog2(REG_COUNT)-1:0] rdAddrA,
  input  logic [$clog2(REG_COUNT)-1:0] rdAddrB,
  output logic [DATA_W-1:0]            rdDataA,
  output logic [DATA_W-1:0]            rdDataB
);
  localparam int AW = $clog2(REG_COUNT);

  logic [DATA_W-1:0] regs [REG_COUNT];

  // register 0 is never stored; its reads are forced to zero below
  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != AW'(0))) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == AW'(0)) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == AW'(0)) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = ($signed(opA) < $signed(opB)) ? DATA_W'(1) : '0;
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/sc_control.sv
`timescale 1ns/1ps
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] func,
  output ctrl_t      ctrl
);
  alu_class_e aluClass;

  always_comb begin
    ctrl     = '0;
    aluClass = CLS_ADD;
    // main decode: one strobe set per opcode
    case (opcode)
      OPC_RTYPE: begin
        ctrl.regWrite = 1'b1;
        ctrl.regDstRd = 1'b1;
        aluClass      = CLS_FUNC;
      end
      OPC_LW: begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memToReg  = 1'b1;
        ctrl.memRead   = 1'b1;
      end
      OPC_SW: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        aluClass    = CLS_SUB;
      end
      OPC_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
    // second level: ALU operation from the class and function field
    case (aluClass)
      CLS_SUB:  ctrl.aluOp = ALU_SUB;
      CLS_FUNC: begin
        case (func)
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          default: ctrl.aluOp = ALU_ADD;
        endcase
      end
      default:  ctrl.aluOp = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_datapath.sv
`timescale 1ns/1ps
module sc_datapath
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrl_t       ctrl,
  output logic [5:0]  opcode,
  output logic [5:0]  func,
  output logic [31:0] pc,
  output logic [31:0] instr,
  output logic        wbEn,
  output logic [4:0]  wbAddr,
  output logic [31:0] wbData,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata
);
  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);

  logic [31:0] instrMem [IMEM_WORDS];
  logic [31:0] dataMem  [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) instrMem[i] = '0;
  end

  logic [31:0] pcReg, pcPlus4, branchTarget, jumpTarget, pcNext;
  logic [31:0] immExt, rdDataA, rdDataB, aluB, aluRes, memRdData;
  logic [4:0]  rsIdx, rtIdx, rdIdx;
  logic        aluZero, takeBranch, regWrEff, memWrEff;

  // fetch
  assign instr   = instrMem[pcReg[IA_W+1:2]];
  assign pcPlus4 = pcReg + 32'd4;

  // field split
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign func   = instr[5:0];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  // strobes are held off while reset is asserted
  assign regWrEff = ctrl.regWrite & ~rst;
  assign memWrEff = ctrl.memWrite & ~rst;

  sc_regfile #(.REG_COUNT(32), .DATA_W(32)) u_rf (
    .clk     (clk),
    .wrEn    (regWrEff),
    .wrAddr  (wbAddr),
    .wrData  (wbData),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

  assign aluB = ctrl.aluSrcImm ? immExt : rdDataB;

  sc_alu #(.DATA_W(32)) u_alu (
    .opA    (rdDataA),
    .opB    (aluB),
    .op     (ctrl.aluOp),
    .result (aluRes),
    .zero   (aluZero)
  );

  // data memory: combinational read, store on the closing edge
  assign memRdData = ctrl.memRead ? dataMem[aluRes[DA_W+1:2]] : '0;

  always_ff @(posedge clk) begin
    if (memWrEff) dataMem[aluRes[DA_W+1:2]] <= rdDataB;
  end

  // write-back selection
  assign wbAddr = ctrl.regDstRd ? rdIdx : rtIdx;
  assign wbData = ctrl.memToReg ? memRdData : aluRes;
  assign wbEn   = regWrEff;

  // next PC: dedicated branch adder runs regardless of the outcome
  assign branchTarget = pcPlus4 + {immExt[29:0], 2'b00};
  assign jumpTarget   = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign takeBranch   = ctrl.branch & aluZero;

  always_comb begin
    if (ctrl.jump)       pcNext = jumpTarget;
    else if (takeBranch) pcNext = branchTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= pcNext;
  end

  assign pc       = pcReg;
  assign memWe    = memWrEff;
  assign memAddr  = aluRes;
  assign memWdata = rdDataB;
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc,
  output logic [31:0] instr,
  output logic        wbEn,
  output logic [4:0]  wbAddr,
  output logic [31:0] wbData,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata
);
  ctrl_t      ctrl;
  logic [5:0] opcode;
  logic [5:0] func;

  sc_control u_ctl (
    .opcode (opcode),
    .func   (func),
    .ctrl   (ctrl)
  );

  sc_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .func     (func),
    .pc       (pc),
    .instr    (instr),
    .wbEn     (wbEn),
    .wbAddr   (wbAddr),
    .wbData   (wbData),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );
endmodule

// File: rtl/sc_core_checker.sv
`timescale 1ns/1ps
module sc_core_checker
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wbEn,
  input logic [4:0]  wbAddr,
  input logic        memWe
);
  logic        isR, isLw, isSw, isBeq, isJmp;
  logic [31:0] pcInc, brOff, jTgt;

  assign isR   = instr[31:26] == OPC_RTYPE;
  assign isLw  = instr[31:26] == OPC_LW;
  assign isSw  = instr[31:26] == OPC_SW;
  assign isBeq = instr[31:26] == OPC_BEQ;
  assign isJmp = instr[31:26] == OPC_JMP;
  assign pcInc = pc + 32'd4;
  assign brOff = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jTgt  = {pcInc[31:28], instr[25:0], 2'b00};

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (!isBeq && !isJmp) |=> pc == $past(pc) + 32'd4);

  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_lw_dest_r6: assert property (@(posedge clk) disable iff (rst)
    isLw |-> (wbEn && wbAddr == instr[20:16]));

  p_store_only_r7: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (isSw && !wbEn));

  p_beq_next_r8: assert property (@(posedge clk) disable iff (rst)
    isBeq |=> (pc == $past(pcInc) || pc == $past(pcInc) + $past(brOff)));

  p_beq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    isBeq |-> (!wbEn && !memWe));

  p_jump_next_r9: assert property (@(posedge clk) disable iff (rst)
    isJmp |=> pc == $past(jTgt));

  p_rtype_dest_r10: assert property (@(posedge clk) disable iff (rst)
    isR |-> (wbEn && wbAddr == instr[15:11]));
endmodule

bind sc_core sc_core_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .pc     (pc),
  .instr  (instr),
  .wbEn   (wbEn),
  .wbAddr (wbAddr),
  .memWe  (memWe)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc, instr, wbData, memAddr, memWdata;
  logic        wbEn, memWe;
  logic [4:0]  wbAddr;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sc_core dut (
    .clk(clk), .rst(rst), .pc(pc), .instr(instr), .wbEn(wbEn),
    .wbAddr(wbAddr), .wbData(wbData), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  logic [31:0] prog  [256];
  logic [31:0] mdmem [64];
  logic [31:0] mregs [32];
  logic [31:0] mpc;

  function automatic logic [31:0] enc_r(logic [5:0] f, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
    return {6'b000000, rs, rt, rd, 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'b000010, idx};
  endfunction

  function automatic logic [31:0] refAlu(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    case (f)
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default:   return a + b;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s at pc %h: actual %h expected %h", tag, what, mpc, act, exp);
    end
  endtask

  task automatic build_program();
    logic [5:0] fn [5];
    int n;
    int cnt;
    fn[0] = 6'b100000; fn[1] = 6'b100010; fn[2] = 6'b100100;
    fn[3] = 6'b100101; fn[4] = 6'b101010;
    for (int i = 0; i < 256; i++) prog[i] = 32'd0;
    for (int i = 0; i < 64; i++) mdmem[i] = 32'h1000 + 32'(i);
    mdmem[0] = 32'd5;         mdmem[1] = 32'hffff_fffd;
    mdmem[2] = 32'h7fff_ffff; mdmem[3] = 32'h8000_0000;
    mdmem[4] = 32'd5;         mdmem[5] = 32'd0;
    mdmem[6] = 32'd64;
    // R6: load r1..r6 and base r27 with zero base register
    for (int k = 0; k < 6; k++) prog[k] = enc_i(6'b100011, 5'd0, 5'(k + 1), 16'(4 * k));
    prog[6] = enc_i(6'b100011, 5'd0, 5'd27, 16'd24);
    // R3/R4 sweep: all ordered pairs of r1..r6 through all five operations
    n = 7; cnt = 0;
    for (int a = 1; a <= 6; a++)
      for (int b = 1; b <= 6; b++)
        for (int f = 0; f < 5; f++) begin
          prog[n] = enc_r(fn[f], 5'(7 + (cnt % 20)), 5'(a), 5'(b));
          n++; cnt++;
        end
    // n == 187
    prog[187] = enc_i(6'b101011, 5'd27, 5'd3, 16'hfff8);   // R7 negative offset store
    prog[188] = enc_i(6'b100011, 5'd27, 5'd28, 16'hfff8);  // R6 reload
    prog[189] = enc_i(6'b101011, 5'd27, 5'd4, 16'd12);
    prog[190] = enc_i(6'b100011, 5'd27, 5'd29, 16'd12);
    prog[191] = enc_r(6'b100000, 5'd0, 5'd1, 5'd2);        // R5 write to r0
    prog[192] = enc_r(6'b100101, 5'd30, 5'd0, 5'd1);       // R5 r0 reads zero
    prog[193] = enc_i(6'b000100, 5'd1, 5'd5, 16'd1);       // R8 taken forward
    prog[194] = enc_r(6'b100000, 5'd31, 5'd1, 5'd1);       // skipped
    prog[195] = enc_i(6'b000100, 5'd1, 5'd2, 16'd3);       // R8 not taken
    prog[196] = enc_j(26'd200);                            // R9
    prog[197] = enc_r(6'b100010, 5'd31, 5'd2, 5'd1);
    prog[198] = enc_j(26'd202);
    prog[199] = enc_r(6'b100000, 5'd31, 5'd1, 5'd1);       // never reached
    prog[200] = enc_r(6'b100000, 5'd31, 5'd3, 5'd4);
    prog[201] = enc_i(6'b000100, 5'd0, 5'd0, 16'hfffb);    // R8 taken backward to 197
    prog[202] = enc_i(6'b101011, 5'd0, 5'd31, 16'd0);
    prog[203] = enc_i(6'b100011, 5'd0, 5'd1, 16'd0);
    prog[204] = enc_j(26'd204);                            // parking loop
  endtask

  string pcTag;

  task automatic step_and_check();
    logic [31:0] ins, a, b, imm, ea, eData, eMa, eMd, npc, pc4;
    logic [5:0]  op, f;
    logic [4:0]  rs, rt, rd, eAddr;
    logic        eWb, eMw;
    string       tag;
    ins = prog[mpc[9:2]];
    op = ins[31:26]; f = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    imm = {{16{ins[15]}}, ins[15:0]};
    a = (rs == 0) ? 32'd0 : mregs[rs];
    b = (rt == 0) ? 32'd0 : mregs[rt];
    pc4 = mpc + 32'd4;
    eWb = 0; eMw = 0; eAddr = 0; eData = 0; eMa = 0; eMd = 0; npc = pc4; tag = "R2";
    case (op)
      6'b000000: begin
        eWb = 1; eAddr = rd; eData = refAlu(f, a, b);
        tag = (f == 6'b101010) ? "R4" : "R3";
        if (rs == 0 || rt == 0 || rd == 0) tag = "R5";
      end
      6'b100011: begin
        eWb = 1; eAddr = rt; ea = a + imm; eData = mdmem[ea[7:2]]; tag = "R6";
      end
      6'b101011: begin
        eMw = 1; eMa = a + imm; eMd = b; tag = "R7";
      end
      6'b000100: begin
        if (a == b) npc = pc4 + {imm[29:0], 2'b00};
        tag = "R8";
      end
      6'b000010: begin
        npc = {pc4[31:28], ins[25:0], 2'b00}; tag = "R9";
      end
      default: ;
    endcase
    chk(pcTag, "pc", pc, mpc);
    chk("R10", "wbEn", 32'(wbEn), 32'(eWb));
    if (eWb) begin
      chk("R10", "wbAddr", 32'(wbAddr), 32'(eAddr));
      chk(tag, "wbData", wbData, eData);
    end
    chk("R7", "memWe", 32'(memWe), 32'(eMw));
    if (eMw) begin
      chk("R7", "memAddr", memAddr, eMa);
      chk("R7", "memWdata", memWdata, eMd);
    end
    if (eWb && eAddr != 0) mregs[eAddr] = eData;
    if (eMw) mdmem[eMa[7:2]] = eMd;
    pcTag = (op == 6'b000100) ? "R8" : (op == 6'b000010) ? "R9" : "R2";
    mpc = npc;
  endtask

  initial begin
    build_program();
    for (int i = 0; i < 32; i++) mregs[i] = 32'd0;
    mpc = 32'd0;
    pcTag = "R1";
    @(negedge clk);
    for (int i = 0; i < 256; i++) dut.u_dp.instrMem[i] = prog[i];
    for (int i = 0; i < 64; i++) dut.u_dp.dataMem[i] = mdmem[i];
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    chk("R1", "pc in reset", pc, 32'd0);
    chk("R1", "wbEn in reset", 32'(wbEn), 32'd0);
    chk("R1", "memWe in reset", 32'(memWe), 32'd0);
    rst = 1'b0;
    #1;
    step_and_check();
    for (int cyc = 0; cyc < 214; cyc++) begin
      @(negedge clk);
      step_and_check();
    end
    // R9 parking loop reached: PC holds at word 204
    chk("R9", "final pc", pc, 32'd816);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule